// File: doc/BRIEF.md
# Clock Sync Rounding Unit

This block lines up a BCD real-time clock with an external reference pulse on an active-low sync pin. Software picks one of three modes with a three-bit one-hot field: 50 Hz lock, round to the nearest second, or round to the nearest minute. The block only reports the 50 Hz mode on its mode outputs. It does not act on it.

The sync pin first passes through a two-flop synchronizer. When the pin falls, the block takes a copy of the hundredths, seconds and minutes counters. It then counts millisecond ticks while the pin stays low. The low time counts as qualified only once it exceeds the configured limit. At that point the block issues one load strobe with the corrected counter values, worked out from the copy.

The correction rounds rather than simply clearing. Second mode clears the hundredths and bumps the seconds when the fraction is past one half. Minute mode clears the seconds and hundredths and bumps the minutes when the seconds are past thirty. Carries ripple through the seconds and minutes, and a minute wrap raises an hour-carry strobe for the hour counter beyond this block.

Top module: `sync_round_unit`

## Requirements
- R1: Mode field bit 0 selects 50 Hz, bit 1 selects nearest second and bit 2 selects nearest minute. With exactly one bit set, the matching mode output is high. With zero bits or two or more bits set, all mode outputs are low and no correction is ever loaded.
- R2: A correction is loaded only when the synchronized sync pin stays low for more than QUAL_TICKS millisecond ticks (default 200). A low pulse shorter than that produces no load strobe.
- R3: Each qualified low pulse produces exactly one load strobe, one clock cycle wide, however long the pin remains low.
- R4: The corrected values are computed from the counter inputs as they stood at the falling edge of the synchronized pin. Later changes to those inputs do not affect the result.
- R5: In nearest-second mode the loaded hundredths are 00. The loaded seconds are the sampled seconds plus one when the sampled hundredths exceed 50, and are unchanged otherwise, so 50 itself does not round up.
- R6: In nearest-second mode, rounding up from second 59 loads second 00 and carries one into the loaded minutes.
- R7: In nearest-minute mode the loaded hundredths and seconds are 00. The loaded minutes are the sampled minutes plus one when the sampled seconds exceed 30, and are unchanged otherwise.
- R8: A minute increment from 59 loads minute 00 and raises hour_carry in the same cycle as the load strobe. hour_carry is never high without a load.
- R9: In 50 Hz mode a qualified low pulse loads nothing.
- R10: After reset the load strobe, hour_carry and all corrected value outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_bits | input | 3 | One-hot mode field: bit 0 selects 50 Hz, bit 1 nearest second, bit 2 nearest minute |
| sync_n | input | 1 | Raw active-low sync pin, asynchronous to clk |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| cur_hund | input | 8 | Current hundredths counter, BCD |
| cur_sec | input | 8 | Current seconds counter, BCD |
| cur_min | input | 8 | Current minutes counter, BCD |
| mode_50hz | output | 1 | Legal 50 Hz mode selected |
| mode_sec | output | 1 | Legal nearest-second mode selected |
| mode_min | output | 1 | Legal nearest-minute mode selected |
| corr_load | output | 1 | One-cycle strobe to load the corrected values |
| corr_hund | output | 8 | Corrected hundredths, BCD |
| corr_sec | output | 8 | Corrected seconds, BCD |
| corr_min | output | 8 | Corrected minutes, BCD |
| hour_carry | output | 1 | Hour increment request, high together with corr_load |

## Verification
The assertions check on every cycle that:
- the mode outputs are never more than one-hot;
- the load strobe lasts a single cycle;
- the loaded fields are cleared as the active mode requires, and are valid BCD below 60;
- hour_carry occurs only together with a load of minute 00.

The directed scenarios cover what no single-cycle property can show:
- the qualification length against the millisecond tick;
- the rounding threshold values 50 and 30;
- the seconds-to-minutes and minutes-to-hours carries;
- the use of counter values frozen at the falling edge;
- the absence of any load under 50 Hz, illegal or short-pulse conditions.

// File: rtl/sync_round_pkg.sv
package sync_round_pkg;

    typedef enum logic [1:0] {
        MODE_NONE,
        MODE_50HZ,
        MODE_SEC,
        MODE_MIN
    } sync_mode_e;

    typedef struct packed {
        logic [7:0] hund;
        logic [7:0] sec;
        logic [7:0] min;
    } bcd_time_t;

    // Increment a BCD value in the range 00..59; bit 8 is the wrap carry.
    function automatic logic [8:0] bcd_inc59(input logic [7:0] v);
        logic [8:0] r;
        if (v[3:0] == 4'd9) begin
            if (v[7:4] == 4'd5) r = {1'b1, 8'h00};
            else                r = {1'b0, v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {1'b0, v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic sync_low,
    output logic sync_fall
);

    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = sync_n;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign sync_low  = ~st_q.stable;
    assign sync_fall = st_q.prev & ~st_q.stable;

endmodule

// File: rtl/sync_qualifier.sv
module sync_qualifier #(
    parameter int QUAL_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_fall,
    input  logic sync_low,
    input  logic ms_tick,
    output logic qual_fire
);

    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } qual_state_t;

    qual_state_t st_d, st_q;
    logic        fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (sync_fall) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (!sync_low) begin
            st_d.armed = 1'b0;
        end else if (st_q.armed && ms_tick) begin
            if (st_q.cnt == LIMIT) begin
                fire       = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual_fire = fire;

endmodule

// File: rtl/sync_round_calc.sv
module sync_round_calc
    import sync_round_pkg::*;
(
    input  sync_mode_e mode,
    input  bcd_time_t  snap,
    output bcd_time_t  result,
    output logic       hour_inc
);

    logic [8:0] sec_step;
    logic [8:0] min_step;

    always_comb begin
        result   = snap;
        hour_inc = 1'b0;
        sec_step = bcd_inc59(snap.sec);
        min_step = bcd_inc59(snap.min);
        unique case (mode)
            MODE_SEC: begin
                result.hund = 8'h00;
                if (snap.hund > 8'h50) begin
                    result.sec = sec_step[7:0];
                    if (sec_step[8]) begin
                        result.min = min_step[7:0];
                        hour_inc   = min_step[8];
                    end
                end
            end
            MODE_MIN: begin
                result.hund = 8'h00;
                result.sec  = 8'h00;
                if (snap.sec > 8'h30) begin
                    result.min = min_step[7:0];
                    hour_inc   = min_step[8];
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sync_round_unit.sv
module sync_round_unit
    import sync_round_pkg::*;
#(
    parameter int QUAL_TICKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_bits,
    input  logic       sync_n,
    input  logic       ms_tick,
    input  logic [7:0] cur_hund,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    output logic       mode_50hz,
    output logic       mode_sec,
    output logic       mode_min,
    output logic       corr_load,
    output logic [7:0] corr_hund,
    output logic [7:0] corr_sec,
    output logic [7:0] corr_min,
    output logic       hour_carry
);

    typedef struct packed {
        bcd_time_t snap;
        bcd_time_t outv;
        logic      load;
        logic      carry;
    } top_state_t;

    top_state_t st_d, st_q;
    sync_mode_e mode;
    logic       sync_low, sync_fall, qual_fire;
    bcd_time_t  calc_res;
    logic       calc_carry;

    always_comb begin
        mode = MODE_NONE;
        if ($countones(mode_bits) == 1) begin
            if (mode_bits[0])      mode = MODE_50HZ;
            else if (mode_bits[1]) mode = MODE_SEC;
            else                   mode = MODE_MIN;
        end
    end

    sync_edge_detect i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n    (sync_n),
        .sync_low  (sync_low),
        .sync_fall (sync_fall)
    );

    sync_qualifier #(.QUAL_TICKS(QUAL_TICKS)) i_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_fall (sync_fall),
        .sync_low  (sync_low),
        .ms_tick   (ms_tick),
        .qual_fire (qual_fire)
    );

    sync_round_calc i_calc (
        .mode     (mode),
        .snap     (st_q.snap),
        .result   (calc_res),
        .hour_inc (calc_carry)
    );

    always_comb begin
        st_d = st_q;
        if (sync_fall) begin
            st_d.snap.hund = cur_hund;
            st_d.snap.sec  = cur_sec;
            st_d.snap.min  = cur_min;
        end
        st_d.load  = qual_fire && (mode == MODE_SEC || mode == MODE_MIN);
        st_d.carry = st_d.load && calc_carry;
        if (st_d.load) st_d.outv = calc_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_50hz  = (mode == MODE_50HZ);
    assign mode_sec   = (mode == MODE_SEC);
    assign mode_min   = (mode == MODE_MIN);
    assign corr_load  = st_q.load;
    assign corr_hund  = st_q.outv.hund;
    assign corr_sec   = st_q.outv.sec;
    assign corr_min   = st_q.outv.min;
    assign hour_carry = st_q.carry;

endmodule

// File: rtl/sync_round_checker.sv
module sync_round_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_50hz,
    input logic       mode_sec,
    input logic       mode_min,
    input logic       corr_load,
    input logic [7:0] corr_hund,
    input logic [7:0] corr_sec,
    input logic [7:0] corr_min,
    input logic       hour_carry
);

    a_r1_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_50hz, mode_sec, mode_min}));

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        corr_load |=> !corr_load);

    a_r9_load_needs_round_mode: assert property (@(posedge clk) disable iff (!rst_n)
        corr_load |-> $past(mode_sec || mode_min));

    a_r5_hund_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        corr_load |-> corr_hund == 8'h00);

    a_r7_sec_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_load && $past(mode_min)) |-> corr_sec == 8'h00);

    a_r6_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
        corr_load |-> (corr_sec < 8'h60 && corr_sec[3:0] < 4'd10 &&
                       corr_min < 8'h60 && corr_min[3:0] < 4'd10));

    a_r8_carry_with_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        hour_carry |-> (corr_load && corr_min == 8'h00));

endmodule

bind sync_round_unit sync_round_checker i_sync_round_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_50hz  (mode_50hz),
    .mode_sec   (mode_sec),
    .mode_min   (mode_min),
    .corr_load  (corr_load),
    .corr_hund  (corr_hund),
    .corr_sec   (corr_sec),
    .corr_min   (corr_min),
    .hour_carry (hour_carry)
);

// File: tb/test_sync_round_unit.sv
module test_sync_round_unit;

    localparam int QUAL = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_bits = 3'b000;
    logic       sync_n = 1'b1;
    logic       ms_tick = 1'b0;
    logic [7:0] cur_hund = 8'h00, cur_sec = 8'h00, cur_min = 8'h00;
    logic       mode_50hz, mode_sec, mode_min, corr_load, hour_carry;
    logic [7:0] corr_hund, corr_sec, corr_min;

    int n_checks = 0;
    int n_fail   = 0;
    int n_loads  = 0;
    int low_ticks = 0;
    int load_ticks = 0;
    logic [7:0] cap_hund, cap_sec, cap_min;
    logic       cap_carry;
    int div = 0;

    sync_round_unit #(.QUAL_TICKS(QUAL)) i_sync_round_unit (
        .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits), .sync_n(sync_n),
        .ms_tick(ms_tick), .cur_hund(cur_hund), .cur_sec(cur_sec), .cur_min(cur_min),
        .mode_50hz(mode_50hz), .mode_sec(mode_sec), .mode_min(mode_min),
        .corr_load(corr_load), .corr_hund(corr_hund), .corr_sec(corr_sec),
        .corr_min(corr_min), .hour_carry(hour_carry)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        div     <= (div == 3) ? 0 : div + 1;
        ms_tick <= (div == 3);
    end

    always @(negedge clk) begin
        if (!sync_n && ms_tick) low_ticks <= low_ticks + 1;
        if (corr_load) begin
            n_loads    <= n_loads + 1;
            load_ticks <= low_ticks;
            cap_hund   <= corr_hund;
            cap_sec    <= corr_sec;
            cap_min    <= corr_min;
            cap_carry  <= hour_carry;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int to_dec(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int d);
        return {4'(d / 10), 4'(d % 10)};
    endfunction

    // Drive a low pulse of the given length in ms ticks, optionally
    // scrambling the counter inputs after the falling edge.
    task automatic pulse(input int ticks, input bit scramble);
        @(negedge clk);
        n_loads   = 0;
        low_ticks = 0;
        sync_n    = 1'b0;
        if (scramble) begin
            repeat (10) @(negedge clk);
            cur_hund = 8'h99; cur_sec = 8'h58; cur_min = 8'h44;
        end
        while (low_ticks < ticks) @(negedge clk);
        sync_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic round_case(input string req, input logic [2:0] md,
                              input logic [7:0] h, input logic [7:0] s,
                              input logic [7:0] m, input bit scramble);
        int eh, es, em, ec;
        mode_bits = md; cur_hund = h; cur_sec = s; cur_min = m;
        eh = 0; es = to_dec(s); em = to_dec(m); ec = 0;
        if (md == 3'b010) begin
            if (to_dec(h) > 50) es++;
            if (es == 60) begin es = 0; em++; end
        end else begin
            if (to_dec(s) > 30) em++;
            es = 0;
        end
        if (em == 60) begin em = 0; ec = 1; end
        pulse(QUAL + 60, scramble);
        check({req, " load count"}, n_loads, 1);
        check({req, " hund"}, int'(cap_hund), int'(to_bcd(eh)));
        check({req, " sec"}, int'(cap_sec), int'(to_bcd(es)));
        check({req, " min"}, int'(cap_min), int'(to_bcd(em)));
        check({req, " hour_carry"}, int'(cap_carry), ec);
        check({req, " R2 qualified late"}, int'(load_ticks >= QUAL), 1);
    endtask

    task automatic t_reset();
        check("R10 load", int'(corr_load), 0);
        check("R10 carry", int'(hour_carry), 0);
        check("R10 values", int'({corr_hund, corr_sec, corr_min}), 0);
    endtask

    task automatic t_modes();
        mode_bits = 3'b001; @(negedge clk);
        check("R1 50hz decode", int'({mode_min, mode_sec, mode_50hz}), 3'b001);
        mode_bits = 3'b010; @(negedge clk);
        check("R1 sec decode", int'({mode_min, mode_sec, mode_50hz}), 3'b010);
        mode_bits = 3'b100; @(negedge clk);
        check("R1 min decode", int'({mode_min, mode_sec, mode_50hz}), 3'b100);
        mode_bits = 3'b110; @(negedge clk);
        check("R1 illegal decode", int'({mode_min, mode_sec, mode_50hz}), 3'b000);
        cur_hund = 8'h77; cur_sec = 8'h12; cur_min = 8'h05;
        pulse(QUAL + 40, 1'b0);
        check("R1 illegal no load", n_loads, 0);
        mode_bits = 3'b000;
        pulse(QUAL + 40, 1'b0);
        check("R1 none no load", n_loads, 0);
    endtask

    task automatic t_50hz();
        mode_bits = 3'b001;
        pulse(QUAL + 40, 1'b0);
        check("R9 50hz no load", n_loads, 0);
    endtask

    task automatic t_short();
        mode_bits = 3'b010; cur_hund = 8'h80;
        pulse(QUAL - 10, 1'b0);
        check("R2 short pulse no load", n_loads, 0);
    endtask

    task automatic t_long();
        mode_bits = 3'b100; cur_sec = 8'h40; cur_min = 8'h10;
        pulse(3 * QUAL, 1'b0);
        check("R3 one load for long pulse", n_loads, 1);
        check("R3 min", int'(cap_min), 8'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_modes();
        t_50hz();
        t_short();
        t_long();
        round_case("R4 R5 round up", 3'b010, 8'h73, 8'h24, 8'h10, 1'b1);
        round_case("R5 hund 50 holds", 3'b010, 8'h50, 8'h24, 8'h10, 1'b0);
        round_case("R5 hund 51 rounds", 3'b010, 8'h51, 8'h09, 8'h33, 1'b0);
        round_case("R6 sec wrap", 3'b010, 8'h88, 8'h59, 8'h20, 1'b0);
        round_case("R6 R8 sec min wrap", 3'b010, 8'h51, 8'h59, 8'h59, 1'b0);
        round_case("R7 sec 31 rounds", 3'b100, 8'h42, 8'h31, 8'h22, 1'b0);
        round_case("R7 sec 30 holds", 3'b100, 8'h42, 8'h30, 8'h22, 1'b1);
        round_case("R8 min wrap", 3'b100, 8'h10, 8'h45, 8'h59, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule